// File: doc/BRIEF.md
# Paged CPU Address Mapper

This block sits between an 8-bit CPU with a 16-bit byte address and a larger byte-wide backing memory. It splits the CPU space into 64 pages of 1 KB. Each page has a descriptor, and the descriptor holds two independent targets: one used for reads and one used for writes. Either target can be switched off on its own. This one scheme covers plain RAM, ROM whose writes vanish, unbacked holes that read as a fill byte, and RAM hidden under ROM.

Descriptors are loaded through a configuration port. One request names a first page, a byte size and a template descriptor. The loader then fills consecutive pages, one per cycle, and steps both physical page numbers by one for each page. The CPU port accepts byte or 16-bit word accesses. A word access is split into two byte accesses in little-endian order, and each byte is translated separately.

Top module: `paged_mapper`

## Requirements
- R1: After reset every page is unmapped. A byte read returns 0x00FF and drives no memory read, and a write drives no memory write. After reset cpu_ready is 1 and cpu_rvalid and cfg_busy are 0.
- R2: CPU address bits [15:10] select the descriptor. The physical address is the selected 8-bit physical page number in bits [17:10], followed by CPU bits [9:0] unchanged in bits [9:0].
- R3: A read from a page whose read target is disabled issues no mem_re and returns the fill byte 0xFF.
- R4: A write to a page whose write target is disabled issues no mem_we, and the backing memory is left unchanged.
- R5: A page may read from one physical page and write to a different one. A write then leaves the read-side data unchanged.
- R6: A byte read asserts cpu_rvalid in the cycle after it is accepted, with the byte in cpu_rdata[7:0] and zero in cpu_rdata[15:8].
- R7: An accepted config request writes npages = cfg_size/1024 consecutive descriptors starting at cfg_base. The k-th descriptor gets physical page numbers cfg_rd_ppn+k and cfg_wr_ppn+k (mod 256). cfg_busy is high for exactly npages cycles, and a cfg_start while busy is ignored.
- R8: A request is rejected if cfg_size[9:0] is non-zero, if npages is zero, or if cfg_base+npages exceeds 64. A rejected request pulses cfg_err for one cycle, never raises cfg_busy, and changes no descriptor.
- R9: A single request with cfg_size = 0x10000 at base 0 maps all 64 pages.
- R10: A word access puts the low byte at addr and the high byte at addr+1, on two consecutive cycles. cpu_ready is 0 in the second cycle. A word read returns {high, low} with cpu_rvalid in the cycle after the second byte.
- R11: The second byte of a word uses addr+1 modulo 65536, so 0xFFFF wraps to 0x0000. Each byte goes through the descriptor of its own page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, taken when cpu_ready is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 16-bit access, 0 = byte |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 16 | Write data, low byte used for byte writes |
| cpu_ready | output | 1 | Low during the second byte of a word |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 16 | Read data |
| cfg_start | input | 1 | Start a mapping request |
| cfg_base | input | 6 | First page to load |
| cfg_size | input | 17 | Request size in bytes |
| cfg_rd_en | input | 1 | Read target present |
| cfg_wr_en | input | 1 | Write target present |
| cfg_rd_ppn | input | 8 | Physical page number for reads of the first page |
| cfg_wr_ppn | input | 8 | Physical page number for writes of the first page |
| cfg_busy | output | 1 | Loader filling descriptors |
| cfg_err | output | 1 | One-cycle pulse on a rejected request |
| mem_re | output | 1 | Backing memory read, data expected the next cycle |
| mem_we | output | 1 | Backing memory write |
| mem_addr | output | 18 | Physical byte address |
| mem_wdata | output | 8 | Physical write data |
| mem_rdata | input | 8 | Physical read data, one cycle after mem_re |

## Verification
The backing memory is seeded with an address-derived pattern, so a byte fetched from the wrong physical page or offset shows up as a wrong value. Directed cases separate five page kinds: RAM, ROM, holes, split read/write pages, and a full-space map. Word accesses straddle a page boundary and the 0xFFFF wrap, which tells per-byte translation apart from translating once per word. Random remaps, with some malformed sizes mixed in, and random byte and word traffic are compared against a bench model of the descriptor table and of memory. Reads made after a write show whether the write landed only where its write target points.

// File: rtl/pmap_pkg.sv
// Shared widths and the page descriptor type for the paged address mapper.
// Assumes a 16-bit CPU byte address and byte-wide backing memory.
package pmap_pkg;
    localparam int CPU_AW    = 16;
    localparam int OFF_W     = 10;
    localparam int VPN_W     = CPU_AW - OFF_W;
    localparam int NUM_PAGES = 1 << VPN_W;
    localparam int PPN_W     = 8;
    localparam int PA_W      = PPN_W + OFF_W;
    localparam int SIZE_W    = CPU_AW + 1;
    localparam int CNT_W     = SIZE_W - OFF_W;

    typedef struct packed {
        logic             rd_en;
        logic             wr_en;
        logic [PPN_W-1:0] rd_ppn;
        logic [PPN_W-1:0] wr_ppn;
    } page_desc_t;
endpackage

// File: rtl/pmap_desc_table.sv
// Descriptor storage plus the loader that fills a run of pages from one request.
// Validates the request size and range, then writes one descriptor per cycle,
// stepping both physical page numbers. Requests that arrive while busy are dropped.
module pmap_desc_table
    import pmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_start,
    input  logic [VPN_W-1:0] cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  page_desc_t       cfg_desc,
    output logic             cfg_busy,
    output logic             cfg_err,
    input  logic [VPN_W-1:0] lkp_vpn,
    output page_desc_t       lkp_desc
);
    logic [CNT_W-1:0] req_pages;
    logic [VPN_W+1:0] req_end;
    logic             req_ok;
    logic             busy_q;
    logic             err_q;
    logic [VPN_W-1:0] cur_vpn;
    logic [CNT_W-1:0] left_q;
    page_desc_t       cur_desc;
    page_desc_t       tbl [NUM_PAGES];

    // Decode the request size into pages and check it fits the space.
    always_comb begin
        req_pages = cfg_size[SIZE_W-1:OFF_W];
        req_end   = {2'b00, cfg_base} + {1'b0, req_pages};
        req_ok    = (cfg_size[OFF_W-1:0] == '0) && (req_pages != '0)
                    && (req_end <= (VPN_W+2)'(NUM_PAGES));
    end

    // Loader sequencing: accept or reject, then walk the page run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            err_q    <= 1'b0;
            cur_vpn  <= '0;
            left_q   <= '0;
            cur_desc <= '0;
        end else begin
            err_q <= 1'b0;
            if (busy_q) begin
                cur_vpn         <= cur_vpn + 1'b1;
                left_q          <= left_q - 1'b1;
                cur_desc.rd_ppn <= cur_desc.rd_ppn + 1'b1;
                cur_desc.wr_ppn <= cur_desc.wr_ppn + 1'b1;
                if (left_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                end
            end else if (cfg_start) begin
                if (req_ok) begin
                    busy_q   <= 1'b1;
                    cur_vpn  <= cfg_base;
                    left_q   <= req_pages;
                    cur_desc <= cfg_desc;
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    // Descriptor array: cleared to unmapped on reset, one entry written per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                tbl[i] <= '0;
            end
        end else if (busy_q) begin
            tbl[cur_vpn] <= cur_desc;
        end
    end

    assign lkp_desc = tbl[lkp_vpn];
    assign cfg_busy = busy_q;
    assign cfg_err  = err_q;
endmodule

// File: rtl/pmap_xlate.sv
// Combinational translation of the active byte access into a physical request.
// Assumes the descriptor given belongs to the page of the active address.
module pmap_xlate
    import pmap_pkg::*;
(
    input  logic             act_valid,
    input  logic             act_we,
    input  logic [OFF_W-1:0] act_off,
    input  page_desc_t       desc,
    output logic             mem_re,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr
);
    // Gate each strobe by its own target and choose that target's page number.
    always_comb begin
        mem_re   = act_valid && !act_we && desc.rd_en;
        mem_we   = act_valid &&  act_we && desc.wr_en;
        mem_addr = {(act_we ? desc.wr_ppn : desc.rd_ppn), act_off};
    end
endmodule

// File: rtl/pmap_access_seq.sv
// CPU access sequencer: passes a byte access straight through and splits a word
// into two byte accesses (addr, then addr+1 with wrap). It assembles read data
// from the backing memory, or the fill byte for pages whose read target is absent.
// Assumes the backing memory returns read data one cycle after mem_re.
module pmap_access_seq
    import pmap_pkg::*;
#(
    parameter logic [7:0] FILL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_word,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [15:0]       cpu_rdata,
    output logic              act_valid,
    output logic              act_we,
    output logic [CPU_AW-1:0] act_addr,
    output logic [7:0]        act_wdata,
    input  logic              act_rd_en,
    input  logic [7:0]        mem_rdata
);
    logic              second_q;
    logic [CPU_AW-1:0] addr2_q;
    logic              we2_q;
    logic [7:0]        hi_q;
    logic              fill_q;
    logic              rv_q;
    logic              rword_q;
    logic [7:0]        lo_q;
    logic [7:0]        cur_byte;

    // Select between the new request and the pending second byte of a word.
    always_comb begin
        act_valid = second_q || cpu_req;
        act_we    = second_q ? we2_q   : cpu_we;
        act_addr  = second_q ? addr2_q : cpu_addr;
        act_wdata = second_q ? hi_q    : cpu_wdata[7:0];
        cur_byte  = fill_q ? FILL : mem_rdata;
    end

    // Track the word phase, the fill choice and read-data validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_q <= 1'b0;
            addr2_q  <= '0;
            we2_q    <= 1'b0;
            hi_q     <= '0;
            fill_q   <= 1'b0;
            rv_q     <= 1'b0;
            rword_q  <= 1'b0;
            lo_q     <= '0;
        end else begin
            rv_q    <= 1'b0;
            rword_q <= 1'b0;
            if (second_q) begin
                second_q <= 1'b0;
                if (!we2_q) begin
                    lo_q    <= cur_byte;
                    fill_q  <= !act_rd_en;
                    rv_q    <= 1'b1;
                    rword_q <= 1'b1;
                end
            end else if (cpu_req) begin
                second_q <= cpu_word;
                addr2_q  <= cpu_addr + CPU_AW'(1);
                we2_q    <= cpu_we;
                hi_q     <= cpu_wdata[15:8];
                if (!cpu_we) begin
                    fill_q <= !act_rd_en;
                    rv_q   <= !cpu_word;
                end
            end
        end
    end

    // Assemble the read result, little-endian for words.
    always_comb begin
        if (!rv_q) begin
            cpu_rdata = '0;
        end else if (rword_q) begin
            cpu_rdata = {cur_byte, lo_q};
        end else begin
            cpu_rdata = {8'h00, cur_byte};
        end
    end

    assign cpu_ready  = !second_q;
    assign cpu_rvalid = rv_q;
endmodule

// File: rtl/paged_mapper.sv
// Top of the paged address mapper: descriptor table with loader, access
// sequencer and translator. Descriptor changes apply to accesses in later cycles.
module paged_mapper
    import pmap_pkg::*;
#(
    parameter logic [7:0] FILL_BYTE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_word,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [15:0]       cpu_rdata,
    input  logic              cfg_start,
    input  logic [VPN_W-1:0]  cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_rd_en,
    input  logic              cfg_wr_en,
    input  logic [PPN_W-1:0]  cfg_rd_ppn,
    input  logic [PPN_W-1:0]  cfg_wr_ppn,
    output logic              cfg_busy,
    output logic              cfg_err,
    output logic              mem_re,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    page_desc_t        cfg_desc;
    page_desc_t        act_desc;
    logic              act_valid;
    logic              act_we;
    logic [CPU_AW-1:0] act_addr;
    logic [7:0]        act_wdata;

    assign cfg_desc = '{rd_en: cfg_rd_en, wr_en: cfg_wr_en,
                        rd_ppn: cfg_rd_ppn, wr_ppn: cfg_wr_ppn};

    pmap_desc_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_start(cfg_start),
        .cfg_base (cfg_base),
        .cfg_size (cfg_size),
        .cfg_desc (cfg_desc),
        .cfg_busy (cfg_busy),
        .cfg_err  (cfg_err),
        .lkp_vpn  (act_addr[CPU_AW-1:OFF_W]),
        .lkp_desc (act_desc)
    );

    pmap_access_seq #(.FILL(FILL_BYTE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_word  (cpu_word),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rvalid(cpu_rvalid),
        .cpu_rdata (cpu_rdata),
        .act_valid (act_valid),
        .act_we    (act_we),
        .act_addr  (act_addr),
        .act_wdata (act_wdata),
        .act_rd_en (act_desc.rd_en),
        .mem_rdata (mem_rdata)
    );

    pmap_xlate u_xlate (
        .act_valid(act_valid),
        .act_we   (act_we),
        .act_off  (act_addr[OFF_W-1:0]),
        .desc     (act_desc),
        .mem_re   (mem_re),
        .mem_we   (mem_we),
        .mem_addr (mem_addr)
    );

    assign mem_wdata = act_wdata;
endmodule

// File: rtl/paged_mapper_chk.sv
// Protocol checker for the paged address mapper, observing top-level ports only.
module paged_mapper_chk
    import pmap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_word,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              cpu_rvalid,
    input logic              cfg_start,
    input logic              cfg_busy,
    input logic              cfg_err,
    input logic              mem_re,
    input logic              mem_we,
    input logic [PA_W-1:0]   mem_addr
);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && (mem_re || mem_we)) |-> (mem_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]));

    // R6
    byte_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !cpu_we && !cpu_word) |=> cpu_rvalid);

    // R8
    cfg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ($past(cfg_start && !cfg_busy) && !cfg_busy));

    // R10
    word_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> $past(cpu_req && cpu_ready && cpu_word));

    // R11
    word_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && cpu_word && (cpu_addr == 16'hFFFF))
        |=> (!(mem_re || mem_we) || (mem_addr[OFF_W-1:0] == '0)));
endmodule

bind paged_mapper paged_mapper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_word  (cpu_word),
    .cpu_addr  (cpu_addr),
    .cpu_ready (cpu_ready),
    .cpu_rvalid(cpu_rvalid),
    .cfg_start (cfg_start),
    .cfg_busy  (cfg_busy),
    .cfg_err   (cfg_err),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
);

// File: tb/tb_paged_mapper.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// checked against a bench model of the descriptor table and backing memory.
module tb_paged_mapper;
    import pmap_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 1 << PA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0, cpu_word = 1'b0;
    logic [15:0]       cpu_addr = '0, cpu_wdata = '0;
    logic              cpu_ready, cpu_rvalid;
    logic [15:0]       cpu_rdata;
    logic              cfg_start = 1'b0, cfg_rd_en = 1'b0, cfg_wr_en = 1'b0;
    logic [VPN_W-1:0]  cfg_base = '0;
    logic [SIZE_W-1:0] cfg_size = '0;
    logic [PPN_W-1:0]  cfg_rd_ppn = '0, cfg_wr_ppn = '0;
    logic              cfg_busy, cfg_err;
    logic              mem_re, mem_we;
    logic [PA_W-1:0]   mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;

    logic [7:0]        phys   [MEM_BYTES];
    logic [7:0]        shadow [MEM_BYTES];
    logic              m_rd [NUM_PAGES];
    logic              m_wr [NUM_PAGES];
    logic [PPN_W-1:0]  m_rp [NUM_PAGES];
    logic [PPN_W-1:0]  m_wp [NUM_PAGES];

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    paged_mapper dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Backing memory: synchronous write, registered read.
    always_ff @(posedge clk) begin
        if (mem_we) phys[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= phys[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        logic [VPN_W-1:0] p = a[15:10];
        if (!m_rd[p]) return 8'hFF;
        return shadow[{m_rp[p], a[9:0]}];
    endfunction

    task automatic do_read(input logic [15:0] a, input bit w, input string req);
        logic [15:0] a2 = a + 16'd1;
        logic [15:0] exp;
        logic [VPN_W-1:0] p = a[15:10];
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_word = w; cpu_addr = a;
        #1;
        chk(mem_re == m_rd[p], req, 32'(mem_re), 32'(m_rd[p]));
        if (m_rd[p]) chk(mem_addr == {m_rp[p], a[9:0]}, "R2", 32'(mem_addr), 32'({m_rp[p], a[9:0]}));
        @(negedge clk);
        cpu_req = 1'b0;
        if (w) begin
            chk(cpu_ready == 1'b0, "R10", 32'(cpu_ready), 32'd0);
            if (m_rd[a2[15:10]])
                chk(mem_addr == {m_rp[a2[15:10]], a2[9:0]}, "R11", 32'(mem_addr), 32'({m_rp[a2[15:10]], a2[9:0]}));
            @(negedge clk);
        end
        exp = w ? {exp_rd(a2), exp_rd(a)} : {8'h00, exp_rd(a)};
        chk(cpu_rvalid == 1'b1, "R6", 32'(cpu_rvalid), 32'd1);
        chk(cpu_rdata == exp, req, 32'(cpu_rdata), 32'(exp));
    endtask

    task automatic do_write(input logic [15:0] a, input bit w, input logic [15:0] d, input string req);
        logic [15:0] a2 = a + 16'd1;
        logic [VPN_W-1:0] p = a[15:10];
        logic [VPN_W-1:0] p2 = a2[15:10];
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_word = w; cpu_addr = a; cpu_wdata = d;
        #1;
        chk(mem_we == m_wr[p], req, 32'(mem_we), 32'(m_wr[p]));
        if (m_wr[p]) begin
            chk(mem_addr == {m_wp[p], a[9:0]}, "R2", 32'(mem_addr), 32'({m_wp[p], a[9:0]}));
            shadow[{m_wp[p], a[9:0]}] = d[7:0];
        end
        @(negedge clk);
        cpu_req = 1'b0;
        if (w) begin
            chk(mem_we == m_wr[p2], "R11", 32'(mem_we), 32'(m_wr[p2]));
            if (m_wr[p2]) shadow[{m_wp[p2], a2[9:0]}] = d[15:8];
        end
    endtask

    task automatic cfg_map(input int base, input int size, input bit rd, input bit wr,
                           input logic [7:0] rp, input logic [7:0] wp, input string req);
        int n = size >> 10;
        bit ok = ((size % 1024) == 0) && (n > 0) && (base + n <= NUM_PAGES);
        int cnt = 0;
        @(negedge clk);
        cfg_start = 1'b1; cfg_base = VPN_W'(base); cfg_size = SIZE_W'(size);
        cfg_rd_en = rd; cfg_wr_en = wr; cfg_rd_ppn = rp; cfg_wr_ppn = wp;
        @(negedge clk);
        cfg_start = 1'b0;
        if (ok) begin
            while (cfg_busy && cnt < 100) begin
                cnt++;
                @(negedge clk);
            end
            chk(cnt == n, req, 32'(cnt), 32'(n));
            for (int k = 0; k < n; k++) begin
                m_rd[base+k] = rd; m_wr[base+k] = wr;
                m_rp[base+k] = rp + 8'(k); m_wp[base+k] = wp + 8'(k);
            end
        end else begin
            chk(cfg_err == 1'b1 && cfg_busy == 1'b0, "R8", {cfg_err, cfg_busy}, 32'd2);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < MEM_BYTES; i++) begin
            phys[i]   = 8'(i) ^ 8'(i >> 8) ^ 8'(i >> 16);
            shadow[i] = phys[i];
        end
        for (int i = 0; i < NUM_PAGES; i++) begin
            m_rd[i] = 0; m_wr[i] = 0; m_rp[i] = '0; m_wp[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cpu_ready && !cpu_rvalid && !cfg_busy, "R1", {cpu_ready, cpu_rvalid, cfg_busy}, 32'h4);
        do_read(16'h1234, 0, "R1");
        do_write(16'h0010, 0, 16'h00AA, "R1");
        // RAM at pages 0..15
        cfg_map(0, 16'h4000, 1, 1, 8'h10, 8'h10, "R7");
        do_write(16'h0123, 0, 16'h005A, "R2");
        do_read(16'h0123, 0, "R2");
        // ROM at pages 16..23
        cfg_map(16, 16'h2000, 1, 0, 8'h40, 8'h40, "R7");
        do_write(16'h4444, 0, 16'h00C3, "R4");
        do_read(16'h4444, 0, "R4");
        // hole read
        do_read(16'hA000, 0, "R3");
        // RAM behind ROM at 24..27
        cfg_map(24, 16'h1000, 1, 1, 8'h50, 8'h60, "R7");
        do_write(16'h6010, 0, 16'h0077, "R5");
        do_read(16'h6010, 0, "R5");
        cfg_map(24, 16'h0400, 1, 1, 8'h60, 8'h60, "R5");
        do_read(16'h6010, 0, "R5");
        // rejected requests
        cfg_map(60, 17'h0401, 1, 1, 8'h20, 8'h20, "R8");
        cfg_map(60, 0, 1, 1, 8'h20, 8'h20, "R8");
        cfg_map(60, 17'h2000, 1, 1, 8'h20, 8'h20, "R8");
        do_read(16'hF000, 0, "R8");
        // start while busy is ignored
        @(negedge clk);
        cfg_start = 1'b1; cfg_base = 6'd40; cfg_size = 17'h0400;
        cfg_rd_en = 1; cfg_wr_en = 1; cfg_rd_ppn = 8'h33; cfg_wr_ppn = 8'h33;
        @(negedge clk);
        cfg_base = 6'd48;
        @(negedge clk);
        cfg_start = 1'b0;
        m_rd[40] = 1; m_wr[40] = 1; m_rp[40] = 8'h33; m_wp[40] = 8'h33;
        repeat (2) @(negedge clk);
        do_read(16'hC000, 0, "R7");
        do_read(16'hA004, 0, "R7");
        // words across page boundary and wrap
        do_write(16'h03FF, 1, 16'hBEEF, "R10");
        do_read(16'h03FF, 1, "R10");
        cfg_map(63, 16'h0400, 1, 1, 8'h70, 8'h70, "R7");
        do_write(16'hFFFF, 1, 16'h1357, "R11");
        do_read(16'hFFFF, 1, "R11");
        do_read(16'h0000, 0, "R11");
        // full space
        cfg_map(0, 17'h10000, 1, 1, 8'h80, 8'h80, "R9");
        do_read(16'hFC00, 0, "R9");
        // random traffic
        for (int it = 0; it < 400; it++) begin
            int sel = int'($urandom_range(0, 9));
            logic [15:0] a = 16'($urandom);
            if (sel == 0) begin
                int b = int'($urandom_range(0, 63));
                int n = int'($urandom_range(1, 64 - b));
                int sz = n * 1024 + ((($urandom_range(0, 7)) == 0) ? 1 : 0);
                cfg_map(b, sz, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), "R7");
            end else if (sel < 5) begin
                do_write(a, 1'($urandom), 16'($urandom), "R4");
            end else begin
                do_read(a, 1'($urandom), "R2");
            end
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule